// File: doc/BRIEF.md
# Single-Flip-Tolerant Content-Addressable Memory

This block is a content-addressable memory. Every entry holds a data word together with a set of check bits. The check bits come from a single-error-correcting Hamming code extended with one overall parity bit. Writes and search keys pass through the same encoder. A search compares the encoded key with every stored codeword in the same clock cycle. An entry counts as a hit when the two codewords differ in at most one bit position.

Because distinct codewords differ in at least four positions, one upset bit in a stored entry still lets its own data be found. A key that differs from the stored data in any bit stays at distance three or more and is rejected. A plain read port returns the raw stored data field. A per-entry valid flag gates matching. A test-only injection port toggles any one stored bit so that upsets can be exercised.

Search results are registered. They give a per-entry hit vector, an any-hit flag and the index of the lowest hitting entry.

Top module: `secded_cam`

## Requirements
- R1: After a synchronous reset, every valid flag is clear and `srch_vld`, `rd_vld`, `hit`, `hit_idx` and `match_vec` are all zero.
- R2: A write stores the encoded word at `wr_addr` and sets that entry's valid flag. A read asserts `rd_vld` one cycle after `rd_en` and returns codeword bits [DATA_W-1:0], the data field, of entry `rd_addr`.
- R3: `srch_vld` pulses one cycle after `srch_en`, together with the registered results. A search sees the contents as they stood before any write made on the same clock edge.
- R4: A valid entry whose stored data equals the key, with no upset bits, is reported in `match_vec`.
- R5: A valid entry whose data differs from the key in any bit is not reported. This holds even when that entry carries one upset bit.
- R6: A valid entry holding the key's data with exactly one toggled codeword bit is still reported.
- R7: An entry holding the key's data with two toggled codeword bits is not reported.
- R8: An entry whose valid flag is clear is never reported. `inv_en` clears the flag of `inv_addr`. A write and an invalidate to the same address in the same cycle leave the entry valid.
- R9: `hit` is high exactly when `match_vec` is non-zero. `hit_idx` is the lowest set position of `match_vec`, and it is zero on a miss.
- R10: `inj_en` toggles bit `inj_bit` of entry `inj_addr`. Bits [DATA_W-1:0] are the data field, which is visible on a read. A value of `inj_bit` at or above the codeword width does nothing. A write to the same entry in the same cycle takes priority over the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry written |
| wr_data | input | DATA_W | Data to encode and store |
| inv_en | input | 1 | Invalidate strobe |
| inv_addr | input | AW | Entry invalidated |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Entry read |
| rd_data | output | DATA_W | Stored data field, registered |
| rd_vld | output | 1 | Read result valid |
| srch_en | input | 1 | Search strobe |
| srch_key | input | DATA_W | Search key data |
| srch_vld | output | 1 | Search result valid |
| match_vec | output | ENTRIES | Per-entry hit vector |
| hit | output | 1 | Any entry hit |
| hit_idx | output | AW | Lowest hitting entry |
| inj_en | input | 1 | Bit-toggle strobe (test only) |
| inj_addr | input | AW | Entry to upset |
| inj_bit | input | BW | Codeword bit to toggle |

## Verification
The assertions assume that `rst` is held for at least one clock and that every strobe is at a known level from then on. The miss and hit properties also assume that no entry accumulates three or more toggled bits. With three upsets, a stored word can fall back within distance one of a different key, and that outcome is outside the guarantee. The stimulus keeps within this bound. It tracks how many upsets each entry holds, injects only while the count is below two, and picks a position distinct from the earlier one. Any write clears the count.

// File: rtl/secded_cam_pkg.sv
package secded_cam_pkg;

  // number of Hamming position bits needed to cover dw data bits
  function automatic int ham_bits(input int dw);
    int r;
    r = 0;
    for (int k = 0; k < 32; k++) begin
      if ((1 << r) < dw + r + 1) r = r + 1;
    end
    return r;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cam_secded_enc.sv
module cam_secded_enc
  import secded_cam_pkg::*;
#(
  parameter int DATA_W = 144,
  parameter int HAM_W  = 8,
  parameter int CODE_W = DATA_W + HAM_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  localparam int LAST_POS = DATA_W + HAM_W;

  logic [HAM_W-1:0] syn;

  // data bit d sits at the d-th non-power-of-two position; each check bit
  // covers the positions whose index has its bit set
  always_comb begin
    int d;
    syn = '0;
    d = 0;
    for (int p = 1; p <= LAST_POS; p++) begin
      if (!is_pow2(p)) begin
        if (d < DATA_W) begin
          for (int j = 0; j < HAM_W; j++) begin
            if (((p >> j) & 1) == 1) syn[j] = syn[j] ^ data[d];
          end
        end
        d = d + 1;
      end
    end
  end

  // layout: {overall parity, Hamming bits, data}
  assign code = {^{syn, data}, syn, data};

endmodule

// File: rtl/cam_dist_cmp.sv
module cam_dist_cmp #(
  parameter int CODE_W = 153
) (
  input  logic              valid,
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] key,
  output logic              near
);
  logic [CODE_W-1:0] diff;
  logic [CODE_W-1:0] diff_dec;

  assign diff     = stored ^ key;
  assign diff_dec = diff - CODE_W'(1);
  // at most one set bit <=> clearing the lowest set bit leaves zero
  assign near     = valid && ((diff & diff_dec) == '0);

endmodule

// File: rtl/cam_lowest_sel.sv
module cam_lowest_sel #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign found = |req;

endmodule

// File: rtl/secded_cam.sv
module secded_cam
  import secded_cam_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 144,
  parameter int AW      = $clog2(ENTRIES),
  parameter int BW      = $clog2(DATA_W + ham_bits(DATA_W) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               inv_en,
  input  logic [AW-1:0]      inv_addr,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_vld,
  input  logic               srch_en,
  input  logic [DATA_W-1:0]  srch_key,
  output logic               srch_vld,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [AW-1:0]      hit_idx,
  input  logic               inj_en,
  input  logic [AW-1:0]      inj_addr,
  input  logic [BW-1:0]      inj_bit
);
  localparam int HAM_W  = ham_bits(DATA_W);
  localparam int CODE_W = DATA_W + HAM_W + 1;

  logic [CODE_W-1:0]  store [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [CODE_W-1:0]  wr_code;
  logic [CODE_W-1:0]  key_code;
  logic [CODE_W-1:0]  inj_mask;
  logic [ENTRIES-1:0] near;
  logic               any_near;
  logic [AW-1:0]      low_idx;

  cam_secded_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CODE_W(CODE_W)) u_wr_enc (
    .data(wr_data), .code(wr_code)
  );

  cam_secded_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CODE_W(CODE_W)) u_key_enc (
    .data(srch_key), .code(key_code)
  );

  // an out-of-range bit index shifts the one out entirely: empty mask
  assign inj_mask = CODE_W'(1) << inj_bit;

  // storage array, no reset; write placed last so it wins over a toggle
  always_ff @(posedge clk) begin
    if (inj_en) store[inj_addr] <= store[inj_addr] ^ inj_mask;
    if (wr_en)  store[wr_addr]  <= wr_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      if (inv_en) valid[inv_addr] <= 1'b0;
      if (wr_en)  valid[wr_addr]  <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      cam_dist_cmp #(.CODE_W(CODE_W)) u_cmp (
        .valid (valid[g]),
        .stored(store[g]),
        .key   (key_code),
        .near  (near[g])
      );
    end
  endgenerate

  cam_lowest_sel #(.N(ENTRIES), .IW(AW)) u_sel (
    .req(near), .found(any_near), .idx(low_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      srch_vld  <= 1'b0;
      match_vec <= '0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      srch_vld <= srch_en;
      if (srch_en) begin
        match_vec <= near;
        hit       <= any_near;
        hit_idx   <= low_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= store[rd_addr][DATA_W-1:0];
    end
  end

  // R3
  srch_lat_chk: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> srch_vld);

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);

  // R9
  hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
    srch_vld |-> (hit == (match_vec != '0)));

  // R9
  idx_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (srch_vld && hit) |-> (match_vec[hit_idx] &&
      ((match_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));

  // R9
  miss_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (srch_vld && !hit) |-> (hit_idx == '0));

  // R8
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    srch_vld |-> ((match_vec & ~$past(valid)) == '0));

endmodule

// File: tb/secded_cam_test.sv
module secded_cam_test;
  localparam int CLK_NS  = 10;
  localparam int ENTRIES = 64;
  localparam int DATA_W  = 144;
  localparam int CODE_W  = 153;
  localparam int AW      = 6;
  localparam int BW      = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, inv_en = 1'b0, rd_en = 1'b0, srch_en = 1'b0, inj_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, inv_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, srch_key = '0;
  logic [BW-1:0] inj_bit = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_vld, srch_vld, hit;
  logic [ENTRIES-1:0] match_vec;
  logic [AW-1:0] hit_idx;

  secded_cam #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inv_en(inv_en), .inv_addr(inv_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld),
    .srch_en(srch_en), .srch_key(srch_key), .srch_vld(srch_vld),
    .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] m_data [ENTRIES];
  logic [DATA_W-1:0] m_rd   [ENTRIES];
  bit                m_val  [ENTRIES];
  int                m_fc   [ENTRIES];
  int                m_fp   [ENTRIES];

  task automatic chk(input bit ok, input string req,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] rnd_data();
    return DATA_W'({$urandom(), $urandom(), $urandom(), $urandom(), $urandom()});
  endfunction

  function automatic logic [ENTRIES-1:0] exp_vec(input logic [DATA_W-1:0] key);
    logic [ENTRIES-1:0] v;
    v = '0;
    for (int i = 0; i < ENTRIES; i++)
      v[i] = m_val[i] && (m_data[i] == key) && (m_fc[i] <= 1);
    return v;
  endfunction

  task automatic model_write(input int a, input logic [DATA_W-1:0] d);
    m_data[a] = d; m_rd[a] = d; m_val[a] = 1'b1; m_fc[a] = 0; m_fp[a] = -1;
  endtask

  task automatic model_inject(input int a, input int b);
    if (b < CODE_W) begin
      m_fc[a]++;
      m_fp[a] = b;
      if (b < DATA_W) m_rd[a][b] = ~m_rd[a][b];
    end
  endtask

  task automatic do_write(input int a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_inval(input int a);
    inv_en = 1'b1; inv_addr = AW'(a);
    tick();
    inv_en = 1'b0;
    m_val[a] = 1'b0;
  endtask

  task automatic do_inject(input int a, input int b);
    inj_en = 1'b1; inj_addr = AW'(a); inj_bit = BW'(b);
    tick();
    inj_en = 1'b0;
    model_inject(a, b);
  endtask

  task automatic do_read(input int a, input string req);
    rd_en = 1'b1; rd_addr = AW'(a);
    tick();
    rd_en = 1'b0;
    chk(rd_vld == 1'b1, {req, " rd_vld"}, DATA_W'(rd_vld), DATA_W'(1));
    chk(rd_data == m_rd[a], {req, " rd_data"}, rd_data, m_rd[a]);
  endtask

  task automatic check_search(input logic [ENTRIES-1:0] ev, input string req);
    logic [AW-1:0] ei;
    ei = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (ev[i]) ei = AW'(i);
    chk(srch_vld == 1'b1, {req, " srch_vld"}, DATA_W'(srch_vld), DATA_W'(1));
    chk(match_vec == ev, {req, " match_vec"}, DATA_W'(match_vec), DATA_W'(ev));
    chk(hit == (ev != '0), "R9 hit", DATA_W'(hit), DATA_W'(ev != '0));
    chk(hit_idx == ei, "R9 hit_idx", DATA_W'(hit_idx), DATA_W'(ei));
  endtask

  task automatic do_search(input logic [DATA_W-1:0] key, input string req);
    logic [ENTRIES-1:0] ev;
    ev = exp_vec(key);
    srch_en = 1'b1; srch_key = key;
    tick();
    srch_en = 1'b0;
    check_search(ev, req);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] k;
    logic [ENTRIES-1:0] ev;
    void'($urandom(32'd4242));
    for (int i = 0; i < ENTRIES; i++) begin
      m_val[i] = 1'b0; m_fc[i] = 0; m_fp[i] = -1; m_data[i] = '0; m_rd[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs after reset
    chk(srch_vld == 1'b0 && rd_vld == 1'b0, "R1 strobes", DATA_W'({srch_vld, rd_vld}), '0);
    chk(hit == 1'b0 && hit_idx == '0, "R1 hit", DATA_W'({hit, hit_idx}), '0);
    chk(match_vec == '0, "R1 match_vec", DATA_W'(match_vec), '0);
    // R1, R8: nothing valid yet
    do_search('0, "R1 empty search");

    // R2: fill and read back
    for (int i = 0; i < ENTRIES; i++) do_write(i, rnd_data());
    for (int i = 0; i < ENTRIES; i += 9) do_read(i, "R2");

    // R4: exact hit
    do_search(m_data[10], "R4 exact");
    // R9: duplicate data, lowest index wins
    do_write(40, m_data[7]);
    do_search(m_data[7], "R9 duplicate");
    // R5: one data bit off
    k = m_data[12]; k[77] = ~k[77];
    do_search(k, "R5 one-bit key");
    // R10, R6: single upset in data field
    do_inject(12, 3);
    do_read(12, "R10 toggled read");
    do_search(m_data[12], "R6 one upset");
    k = m_data[12]; k[3] = ~k[3];
    do_search(k, "R5 key equals upset data");
    // R6: upset in a check bit
    do_inject(20, 150);
    do_search(m_data[20], "R6 check upset");
    // R7: second upset
    do_inject(12, 148);
    do_search(m_data[12], "R7 two upsets");
    // R10: out-of-range bit index ignored
    do_inject(30, 200);
    do_read(30, "R10 out-of-range read");
    do_search(m_data[30], "R10 out-of-range search");
    // R8: invalidate, duplicate now found at 40
    do_inval(7);
    do_search(m_data[40], "R8 invalidated");
    // R8: write and invalidate together leave entry valid
    k = rnd_data();
    wr_en = 1'b1; wr_addr = AW'(9); wr_data = k; inv_en = 1'b1; inv_addr = AW'(9);
    tick();
    wr_en = 1'b0; inv_en = 1'b0;
    model_write(9, k);
    do_search(k, "R8 write beats invalidate");
    // R3: search sees contents before a same-edge write
    k = m_data[50];
    ev = exp_vec(k);
    srch_en = 1'b1; srch_key = k; wr_en = 1'b1; wr_addr = AW'(50); wr_data = rnd_data();
    tick();
    srch_en = 1'b0; wr_en = 1'b0;
    model_write(50, wr_data);
    check_search(ev, "R3 search before write");
    do_search(k, "R3 after write");
    // R10: write beats toggle on same entry
    k = rnd_data();
    wr_en = 1'b1; wr_addr = AW'(33); wr_data = k;
    inj_en = 1'b1; inj_addr = AW'(33); inj_bit = BW'(5);
    tick();
    wr_en = 1'b0; inj_en = 1'b0;
    model_write(33, k);
    do_read(33, "R10 write beats toggle");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op, a, b;
      op = int'($urandom_range(9));
      a = int'($urandom_range(ENTRIES - 1));
      case (op)
        0, 1: begin
          if ($urandom_range(3) == 0) do_write(a, m_data[int'($urandom_range(ENTRIES - 1))]);
          else do_write(a, rnd_data());
        end
        2: do_inval(a);
        3: begin
          if (m_fc[a] < 2) begin
            b = int'($urandom_range(CODE_W - 1));
            if (b == m_fp[a]) b = (b + 1) % CODE_W;
            do_inject(a, b);
          end
        end
        4: do_read(a, "R2 random read");
        default: begin
          k = m_data[a];
          if ($urandom_range(2) == 0) begin
            b = int'($urandom_range(DATA_W - 1));
            k[b] = ~k[b];
            do_search(k, "R5 random near key");
          end else begin
            do_search(k, "R6 random search");
          end
        end
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule